// File: doc/BRIEF.md
# Hub Traffic Path Router

This block sits between the per-port logic of a USB 2.0 hub and its two traffic engines. There is a repeater path for same-speed traffic and one transaction translator that all ports share. For every downstream port it picks the engine that carries that port's traffic in both directions. The choice is based on the negotiated upstream speed and on the speed of the device attached to the port.

When the upstream link runs at high speed, full-speed and low-speed ports can all need the single translator. A port asks for it with a request line, and the block hands it to one port at a time in round-robin order. The request/grant pair behaves as valid/ready. A requester keeps its request raised until it sees its grant, and the owner keeps the translator for as long as it holds its request.

The block also holds a global suspend indication. A wakeup event on any port while the hub is suspended produces a one-cycle internal resume pulse and ends the suspend.

Top module: `hub_route_ctrl`

## Requirements
- R1: With the upstream link at full speed (`us_hs`=0), every attached port that is idle is routed to the repeater (`route_rep`=1, `route_tt`=0) after the next clock edge, whatever its device speed.
- R2: With the upstream link at high speed (`us_hs`=1), an attached idle port whose device is high speed (`port_hs`=1) is routed to the repeater after the next clock edge.
- R3: With the upstream link at high speed, an attached idle port whose device is full or low speed (`port_hs`=0) is routed to the translator (`route_tt`=1, `route_rep`=0) after the next clock edge.
- R4: While an attached port has `port_busy`=1, its route outputs keep their value even if the upstream or device speed inputs change.
- R5: A port with `port_attached`=0 has both route outputs at 0 after the next clock edge, even when its `port_busy` is 1.
- R6: At most one bit of `tt_gnt` is set. A grant goes only to a port that requested in the previous cycle while routed to the translator. A port not routed to the translator never receives a grant.
- R7: A grant appears one cycle after the request. The owner keeps the grant while it holds its request. When the owner releases, the next grant goes to the first requester found by searching upward from the previous owner and wrapping. After reset the search starts at port 0.
- R8: While `susp_ind`=1, a wakeup event on any port makes `resume_pulse` 1 for exactly one cycle, starting after the next edge. At that same edge `susp_ind` drops to 0.
- R9: A wakeup event while `susp_ind`=0 produces no resume pulse.
- R10: `suspend_enter`=1 sets `susp_ind` after the next edge. After reset, all route outputs, `tt_gnt`, `susp_ind` and `resume_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_hs | input | 1 | Upstream link speed: 1 high speed, 0 full speed |
| port_attached | input | NUM_PORTS | Device present on each port |
| port_hs | input | NUM_PORTS | Attached device is high speed |
| port_busy | input | NUM_PORTS | Packet in flight on the port; freezes its route |
| tt_req | input | NUM_PORTS | Translator request (valid) per port |
| suspend_enter | input | 1 | Hub enters global suspend |
| wake_evt | input | NUM_PORTS | Wakeup event per port |
| route_rep | output | NUM_PORTS | Port traffic goes through the repeater |
| route_tt | output | NUM_PORTS | Port traffic goes through the translator |
| tt_gnt | output | NUM_PORTS | One-hot translator ownership (ready) |
| susp_ind | output | 1 | Global suspend indication |
| resume_pulse | output | 1 | One-cycle internal resume request |

## Verification
Every result of this block is one register stage away from its cause. Route outputs follow the speed, attach and busy inputs after one edge. A grant follows the request it answers after one edge. The suspend indication and the resume pulse follow `suspend_enter` and a wakeup event after one edge. The bench changes inputs on the falling edge, waits for exactly one rising edge, and samples 1 ns later. It then samples once more a cycle later wherever the one-cycle width of the pulse, or the holding of a route or grant, is the thing being tested.

// File: rtl/hub_route_pkg.sv
package hub_route_pkg;

  typedef enum logic [1:0] {
    PATH_NONE = 2'd0,
    PATH_REP  = 2'd1,
    PATH_TT   = 2'd2
  } path_e;

  // Path a port should take given link and device speeds.
  function automatic path_e pick_path(input logic attached,
                                      input logic up_hs,
                                      input logic dev_hs);
    if (!attached)            return PATH_NONE;
    else if (!up_hs || dev_hs) return PATH_REP;
    else                       return PATH_TT;
  endfunction

endpackage

// File: rtl/hub_port_path.sv
module hub_port_path
  import hub_route_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  up_hs,
  input  logic  attached,
  input  logic  dev_hs,
  input  logic  busy,
  output path_e path_q
);

  path_e path_d;

  always_comb begin
    path_d = path_q;
    if (!attached)  path_d = PATH_NONE;                       // detach wins
    else if (!busy) path_d = pick_path(attached, up_hs, dev_hs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) path_q <= PATH_NONE;
    else        path_q <= path_d;
  end

endmodule

// File: rtl/hub_tt_arbiter.sv
module hub_tt_arbiter #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req,
  input  logic [NUM_PORTS-1:0] on_tt,
  output logic [NUM_PORTS-1:0] gnt_q
);

  localparam int PTR_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [PTR_W-1:0] PTR_INIT = PTR_W'(NUM_PORTS - 1);

  logic [NUM_PORTS-1:0] elig;
  logic [NUM_PORTS-1:0] pick;
  logic [NUM_PORTS-1:0] gnt_d;
  logic [PTR_W-1:0]     ptr_q;
  logic [PTR_W-1:0]     pick_idx;
  logic                 found;
  logic                 hold;

  assign elig = req & on_tt;
  assign hold = |(gnt_q & elig);

  always_comb begin
    pick     = '0;
    pick_idx = ptr_q;
    found    = 1'b0;
    for (int off = 1; off <= NUM_PORTS; off++) begin
      int idx;
      idx = (int'(ptr_q) + off) % NUM_PORTS;
      if (!found && elig[idx]) begin
        found       = 1'b1;
        pick[idx]   = 1'b1;
        pick_idx    = PTR_W'(idx);
      end
    end
  end

  assign gnt_d = hold ? gnt_q : pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      ptr_q <= PTR_INIT;
    end else begin
      gnt_q <= gnt_d;
      if (!hold && found) ptr_q <= pick_idx;
    end
  end

endmodule

// File: rtl/hub_resume_gen.sv
module hub_resume_gen #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enter,
  input  logic [NUM_PORTS-1:0] wake,
  output logic                 susp_q,
  output logic                 pulse_q
);

  logic fire;
  assign fire = susp_q && (|wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (fire)       susp_q <= 1'b0;
      else if (enter) susp_q <= 1'b1;
    end
  end

endmodule

// File: rtl/hub_route_ctrl.sv
module hub_route_ctrl
  import hub_route_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 us_hs,
  input  logic [NUM_PORTS-1:0] port_attached,
  input  logic [NUM_PORTS-1:0] port_hs,
  input  logic [NUM_PORTS-1:0] port_busy,
  input  logic [NUM_PORTS-1:0] tt_req,
  input  logic                 suspend_enter,
  input  logic [NUM_PORTS-1:0] wake_evt,
  output logic [NUM_PORTS-1:0] route_rep,
  output logic [NUM_PORTS-1:0] route_tt,
  output logic [NUM_PORTS-1:0] tt_gnt,
  output logic                 susp_ind,
  output logic                 resume_pulse
);

  path_e path [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    hub_port_path u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_hs    (us_hs),
      .attached (port_attached[p]),
      .dev_hs   (port_hs[p]),
      .busy     (port_busy[p]),
      .path_q   (path[p])
    );
    assign route_rep[p] = (path[p] == PATH_REP);
    assign route_tt[p]  = (path[p] == PATH_TT);
  end

  hub_tt_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (tt_req),
    .on_tt (route_tt),
    .gnt_q (tt_gnt)
  );

  hub_resume_gen #(.NUM_PORTS(NUM_PORTS)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter   (suspend_enter),
    .wake    (wake_evt),
    .susp_q  (susp_ind),
    .pulse_q (resume_pulse)
  );

endmodule

// File: rtl/hub_route_ctrl_chk.sv
module hub_route_ctrl_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 us_hs,
  input logic [NUM_PORTS-1:0] port_attached,
  input logic [NUM_PORTS-1:0] port_busy,
  input logic [NUM_PORTS-1:0] tt_req,
  input logic [NUM_PORTS-1:0] wake_evt,
  input logic [NUM_PORTS-1:0] route_rep,
  input logic [NUM_PORTS-1:0] route_tt,
  input logic [NUM_PORTS-1:0] tt_gnt,
  input logic                 susp_ind,
  input logic                 resume_pulse
);

  // R1: no port newly moves to the translator while the link is full speed
  a_r1_no_new_tt_at_fs: assert property (@(posedge clk) disable iff (!rst_n)
    !us_hs |=> ((route_tt & ~$past(route_tt)) == '0));

  // R4: a busy attached port keeps its route across the edge
  a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    |(port_busy & port_attached) |=>
      ((($past(port_busy & port_attached)) &
        ((route_tt ^ $past(route_tt)) | (route_rep ^ $past(route_rep)))) == '0));

  // R5: a detached port has no route after the edge
  a_r5_detach_clears: assert property (@(posedge clk) disable iff (!rst_n)
    |(~port_attached) |=> (((route_rep | route_tt) & ~$past(port_attached)) == '0));

  // R6: at most one translator owner
  a_r6_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tt_gnt));

  // R6: grant only to a port that requested while on the translator
  a_r6_gnt_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    |tt_gnt |-> ((tt_gnt & ~$past(tt_req & route_tt)) == '0));

  // R8: resume pulse lasts one cycle and ends the suspend
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  a_r8_pulse_clears_susp: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> !susp_ind);

  // R9: a pulse always has a wakeup during suspend as its cause
  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> $past(susp_ind && (|wake_evt)));

endmodule

bind hub_route_ctrl hub_route_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .us_hs         (us_hs),
  .port_attached (port_attached),
  .port_busy     (port_busy),
  .tt_req        (tt_req),
  .wake_evt      (wake_evt),
  .route_rep     (route_rep),
  .route_tt      (route_tt),
  .tt_gnt        (tt_gnt),
  .susp_ind      (susp_ind),
  .resume_pulse  (resume_pulse)
);

// File: tb/hub_route_ctrl_test.sv
`timescale 1ns/1ps
module hub_route_ctrl_test;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         us_hs = 1'b0;
  logic [N-1:0] port_attached = '0;
  logic [N-1:0] port_hs = '0;
  logic [N-1:0] port_busy = '0;
  logic [N-1:0] tt_req = '0;
  logic         suspend_enter = 1'b0;
  logic [N-1:0] wake_evt = '0;
  logic [N-1:0] route_rep, route_tt, tt_gnt;
  logic         susp_ind, resume_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  hub_route_ctrl #(.NUM_PORTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .us_hs(us_hs), .port_attached(port_attached),
    .port_hs(port_hs), .port_busy(port_busy), .tt_req(tt_req),
    .suspend_enter(suspend_enter), .wake_evt(wake_evt),
    .route_rep(route_rep), .route_tt(route_tt), .tt_gnt(tt_gnt),
    .susp_ind(susp_ind), .resume_pulse(resume_pulse)
  );

  // {us_hs, attached, dev_hs, expected rep, expected tt}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 4'b1111, 4'b0000, 4'b1111, 4'b0000},  // R1
    {1'b0, 4'b1010, 4'b0101, 4'b1010, 4'b0000},  // R1 R5
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 4'b0000},  // R2
    {1'b1, 4'b1111, 4'b0000, 4'b0000, 4'b1111},  // R3
    {1'b1, 4'b1111, 4'b0110, 4'b0110, 4'b1001},  // R2 R3
    {1'b1, 4'b0110, 4'b0010, 4'b0010, 4'b0100},  // R3 R5
    {1'b1, 4'b0000, 4'b1111, 4'b0000, 4'b0000},  // R5
    {1'b0, 4'b1001, 4'b1000, 4'b1001, 4'b0000}   // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic drive_at_negedge;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 reset rep", route_rep, 0);
    check("R10 reset tt", route_tt, 0);
    check("R10 reset gnt", tt_gnt, 0);
    check("R10 reset susp", susp_ind, 0);
    check("R10 reset pulse", resume_pulse, 0);
    drive_at_negedge();
    rst_n = 1'b1;

    // Table of routing vectors
    for (int i = 0; i < 8; i++) begin
      drive_at_negedge();
      us_hs         = VEC[i][16];
      port_attached = VEC[i][15:12];
      port_hs       = VEC[i][11:8];
      step();
      check("R1/R2/R3/R5 rep", route_rep, VEC[i][7:4]);
      check("R1/R2/R3/R5 tt", route_tt, VEC[i][3:0]);
    end

    // R4: busy port keeps translator route while speeds change
    drive_at_negedge();
    us_hs = 1'b1; port_attached = 4'b1111; port_hs = 4'b0000; port_busy = 4'b0000;
    step();
    drive_at_negedge();
    port_busy = 4'b0001; port_hs = 4'b1111;
    step();
    check("R4 busy hold tt", route_tt, 4'b0001);
    check("R4 idle move rep", route_rep, 4'b1110);
    // R4: link drop to full speed also does not move a busy port
    drive_at_negedge();
    us_hs = 1'b0;
    step();
    check("R4 busy hold on link change", route_tt, 4'b0001);
    // R5: detach overrides busy
    drive_at_negedge();
    port_attached = 4'b1110;
    step();
    check("R5 detach while busy tt", route_tt, 4'b0000);
    check("R5 detach while busy rep", route_rep, 4'b1110);

    // Arbitration: all ports on translator
    drive_at_negedge();
    us_hs = 1'b1; port_attached = 4'b1111; port_hs = 4'b0000; port_busy = 4'b0000;
    step();
    check("R3 all tt", route_tt, 4'b1111);
    drive_at_negedge();
    tt_req = 4'b1010;
    step();
    check("R7 first grant from port0 search", tt_gnt, 4'b0010);
    step();
    check("R7 owner holds", tt_gnt, 4'b0010);
    drive_at_negedge();
    tt_req = 4'b1000;
    step();
    check("R7 next after release", tt_gnt, 4'b1000);
    drive_at_negedge();
    tt_req = 4'b0111;
    step();
    check("R7 wrap to port0", tt_gnt, 4'b0001);
    drive_at_negedge();
    tt_req = 4'b0110;
    step();
    check("R7 rotate to port1", tt_gnt, 4'b0010);
    drive_at_negedge();
    tt_req = 4'b0000;
    step();
    check("R6 no request no grant", tt_gnt, 4'b0000);
    // R6: port on repeater cannot win the translator
    drive_at_negedge();
    port_hs = 4'b0001;
    step();
    drive_at_negedge();
    tt_req = 4'b0001;
    step();
    check("R6 repeater port not granted", tt_gnt, 4'b0000);
    step();
    check("R6 repeater port still not granted", tt_gnt, 4'b0000);
    drive_at_negedge();
    tt_req = 4'b0000;

    // Suspend and resume
    drive_at_negedge();
    wake_evt = 4'b0100;
    step();
    check("R9 wake while awake no pulse", resume_pulse, 0);
    drive_at_negedge();
    wake_evt = 4'b0000; suspend_enter = 1'b1;
    step();
    check("R10 suspend set", susp_ind, 1);
    drive_at_negedge();
    suspend_enter = 1'b0;
    step();
    check("R8 no pulse without wake", resume_pulse, 0);
    drive_at_negedge();
    wake_evt = 4'b0100;
    step();
    check("R8 pulse", resume_pulse, 1);
    check("R8 suspend cleared", susp_ind, 0);
    drive_at_negedge();
    wake_evt = 4'b0000;
    step();
    check("R8 pulse one cycle", resume_pulse, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule